// File: doc/BRIEF.md
# Parity-Protected Word Memory

This block is a word-organised storage array with one protection bit per 32-bit word. An initiator reaches it through a valid/ready request channel and a valid/ready read-response channel. The protection bit is even parity: it is 1 when the word holds an odd number of ones. While checking is switched on, every data write stores a fresh protection bit and every data read checks it. While checking is off, data writes leave the stored bit alone and reads are not checked.

A failed check never holds back the read data. Instead it sets a sticky error flag, can raise an interrupt, latches the failing word number, and sends a one-cycle clear pulse to the owner of that word. The owner uses the pulse to drop its pending-transmit flag. A test path lets software read the protection bits, and in a test mode with checking off it can also write them, so that errors can be injected on purpose. An initialisation sweep zeroes the whole array.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low during the init sweep, and also while a read response is waiting with `rsp_ready` low. A read response appears one cycle after the request is taken. It holds its data stable until it is taken with `rsp_ready`. Writes produce no response.

Top module: `parity_msg_ram`

## Requirements
- R1: A pulse on `init_start` makes `init_busy` high for exactly DEPTH cycles. During this time `req_ready` is low and every word is written with data 0 and protection bit 0. Afterwards every word reads 0, its protection bit reads 0, and no error is raised.
- R2: With `par_en` high, a data write (`req_par_sel`=0) stores the word and also stores the XOR of its 32 bits as the protection bit.
- R3: With `par_en` low, a data write stores the word and leaves the stored protection bit unchanged. A data read with `par_en` low never raises an error.
- R4: `rsp_valid` rises one cycle after a read is taken and carries the stored word, whether or not the check fails. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` is held stable and `req_ready` is low.
- R5: A data read taken with `par_en` high whose word XOR differs from the stored bit sets `par_err` one cycle after `rsp_valid` rises. `par_err` stays high until `err_clr`.
- R6: The same error latches the read word number into `err_addr`. A later error overwrites it.
- R7: The same error gives a single-cycle `obj_clr_valid` pulse, aligned with `par_err` rising, with `obj_clr_addr` equal to the failing word number.
- R8: `err_irq` is high exactly when `par_err` and `irq_en` are both high.
- R9: A read with `req_par_sel`=1 returns the stored protection bit in `rsp_rdata` bit 0, with the other bits 0, when `rda_mode` or `dbg_mode` is high. Otherwise it returns 0. Such reads are never checked.
- R10: A write with `req_par_sel`=1 stores `req_wdata` bit 0 as the protection bit only when (`rda_mode` or `dbg_mode`) is high and `par_en` is low. Otherwise it changes nothing.
- R11: An `err_clr` pulse clears `par_err`, `err_addr` and `err_irq` on the next edge. An error detected in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_par_sel | input | 1 | 1 = access the protection bit, 0 = data word |
| req_addr | input | ADDR_W | Word number |
| req_wdata | input | 32 | Write data (bit 0 for protection writes) |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 32 | Read response data |
| par_en | input | 1 | Parity generation and checking enable |
| rda_mode | input | 1 | Direct test-access mode |
| dbg_mode | input | 1 | Debug mode |
| irq_en | input | 1 | Error interrupt enable |
| init_start | input | 1 | Start the zeroing sweep |
| init_busy | output | 1 | Sweep in progress |
| err_clr | input | 1 | Clear the error flag and address |
| par_err | output | 1 | Sticky parity error flag |
| err_addr | output | ADDR_W | Word number of the last failing read |
| err_irq | output | 1 | Error interrupt |
| obj_clr_valid | output | 1 | Pulse to clear the owner's pending flag |
| obj_clr_addr | output | ADDR_W | Word number for that pulse |

## Verification
The bench builds the block with DEPTH of 16 words. At that depth the whole zeroing sweep is short enough to count cycle by cycle, and the top word number, 15, can be read back as a boundary. Errors are injected through the protection-bit write path and through stale bits left by writes made with checking off. Two failing words are then used to show that the latched word number is overwritten.

// File: rtl/pram_pkg.sv
package pram_pkg;
  parameter int unsigned WORD_W = 32;

  typedef enum logic {
    ACC_DATA = 1'b0,
    ACC_PBIT = 1'b1
  } acc_kind_e;

  function automatic logic word_parity(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction
endpackage

// File: rtl/pram_init_seq.sv
module pram_init_seq #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              wen,
  output logic [ADDR_W-1:0] waddr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy  = busy_q;
  assign wen   = busy_q;
  assign waddr = cnt_q;
endmodule

// File: rtl/pram_array.sv
module pram_array #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              d_we,
  input  logic [WIDTH-1:0]  d_val,
  input  logic              p_we,
  input  logic              p_val,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_par
);
  logic [WIDTH-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0] par_bits;

  always_ff @(posedge clk) begin
    if (d_we) data_mem[waddr] <= d_val;
    if (re)   rd_data <= data_mem[raddr];
  end

  // one flop per word for the protection bits, each with its own enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_pbit
    always_ff @(posedge clk) begin
      if (p_we && waddr == ADDR_W'(g)) par_bits[g] <= p_val;
    end
  end

  always_ff @(posedge clk) begin
    if (re) rd_par <= par_bits[raddr];
  end
endmodule

// File: rtl/pram_err_log.sv
module pram_err_log #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              clr,
  input  logic              irq_en,
  output logic              flag,
  output logic [ADDR_W-1:0] addr,
  output logic              irq,
  output logic              pulse,
  output logic [ADDR_W-1:0] pulse_addr
);
  logic              flag_q, pulse_q;
  logic [ADDR_W-1:0] addr_q, paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      addr_q  <= '0;
      pulse_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      pulse_q <= hit;
      if (hit) begin
        flag_q  <= 1'b1;
        addr_q  <= hit_addr;
        paddr_q <= hit_addr;
      end else if (clr) begin
        flag_q <= 1'b0;
        addr_q <= '0;
      end
    end
  end

  assign flag       = flag_q;
  assign addr       = addr_q;
  assign irq        = flag_q & irq_en;
  assign pulse      = pulse_q;
  assign pulse_addr = paddr_q;
endmodule

// File: rtl/parity_msg_ram.sv
module parity_msg_ram
  import pram_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_par_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              par_en,
  input  logic              rda_mode,
  input  logic              dbg_mode,
  input  logic              irq_en,
  input  logic              init_start,
  output logic              init_busy,
  input  logic              err_clr,
  output logic              par_err,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_irq,
  output logic              obj_clr_valid,
  output logic [ADDR_W-1:0] obj_clr_addr
);
  localparam int unsigned W = WORD_W;

  logic              iw_en;
  logic [ADDR_W-1:0] iw_addr;
  logic              take, test_ok, wr_data, wr_pbit, rd_take;
  logic              d_we, p_we, p_val;
  logic [W-1:0]      d_val;
  logic [W-1:0]      arr_data;
  logic              arr_par;
  logic              rsp_q, fresh_q, chk_q, test_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] raddr_q;
  logic              err_hit;

  pram_init_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_init (
    .clk(clk), .rst_n(rst_n), .start(init_start),
    .busy(init_busy), .wen(iw_en), .waddr(iw_addr)
  );

  assign req_ready = !init_busy && (!rsp_q || rsp_ready);
  assign take      = req_valid && req_ready;
  assign test_ok   = rda_mode || dbg_mode;
  assign wr_data   = take && req_we && (req_par_sel == ACC_DATA);
  assign wr_pbit   = take && req_we && (req_par_sel == ACC_PBIT) && test_ok && !par_en;
  assign rd_take   = take && !req_we;

  always_comb begin
    d_we  = iw_en || wr_data;
    d_val = iw_en ? '0 : req_wdata;
    p_we  = iw_en || (wr_data && par_en) || wr_pbit;
    if (iw_en)        p_val = 1'b0;
    else if (wr_pbit) p_val = req_wdata[0];
    else              p_val = word_parity(req_wdata);
  end

  pram_array #(.DEPTH(DEPTH), .WIDTH(W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .d_we(d_we), .d_val(d_val), .p_we(p_we), .p_val(p_val),
    .waddr(iw_en ? iw_addr : req_addr), .re(rd_take), .raddr(req_addr),
    .rd_data(arr_data), .rd_par(arr_par)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      fresh_q <= 1'b0;
      chk_q   <= 1'b0;
      test_q  <= 1'b0;
      kind_q  <= ACC_DATA;
      raddr_q <= '0;
    end else begin
      fresh_q <= rd_take;
      if (rd_take) begin
        rsp_q   <= 1'b1;
        kind_q  <= acc_kind_e'(req_par_sel);
        chk_q   <= par_en && (req_par_sel == ACC_DATA);
        test_q  <= test_ok;
        raddr_q <= req_addr;
      end else if (rsp_ready) begin
        rsp_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_q;
  always_comb begin
    if (kind_q == ACC_DATA) rsp_rdata = arr_data;
    else                    rsp_rdata = {{(W-1){1'b0}}, arr_par & test_q};
  end

  assign err_hit = fresh_q && chk_q && !init_busy &&
                   (word_parity(arr_data) != arr_par);

  pram_err_log #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .hit(err_hit), .hit_addr(raddr_q),
    .clr(err_clr), .irq_en(irq_en), .flag(par_err), .addr(err_addr),
    .irq(err_irq), .pulse(obj_clr_valid), .pulse_addr(obj_clr_addr)
  );
endmodule

// File: rtl/parity_msg_ram_chk.sv
module parity_msg_ram_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              irq_en,
  input logic              init_busy,
  input logic              err_clr,
  input logic              par_err,
  input logic [ADDR_W-1:0] err_addr,
  input logic              err_irq,
  input logic              obj_clr_valid,
  input logic [ADDR_W-1:0] obj_clr_addr
);
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !req_ready);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r4_stall_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);

  a_r7_pulse_matches: assert property (@(posedge clk) disable iff (!rst_n)
    obj_clr_valid |-> (par_err && err_addr == obj_clr_addr));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (par_err && irq_en));

  a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_clr) && !obj_clr_valid) |-> (!par_err && err_addr == '0));
endmodule

bind parity_msg_ram parity_msg_ram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/parity_msg_ram_bench.sv
module parity_msg_ram_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, req_par_sel = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic par_en = 0, rda_mode = 0, dbg_mode = 0, irq_en = 0, init_start = 0, err_clr = 0;
  logic req_ready, rsp_valid, init_busy, par_err, err_irq, obj_clr_valid;
  logic [31:0] rsp_rdata;
  logic [AW-1:0] err_addr, obj_clr_addr;
  int checks = 0, errors = 0;
  logic [31:0] rd;
  logic seen_pulse;

  always #2 clk = ~clk;

  parity_msg_ram #(.DEPTH(DEPTH), .ADDR_W(AW)) u_parity_msg_ram (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic psel, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_par_sel = psel; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  // read; result in rd; seen_pulse reflects obj_clr_valid one cycle after response
  task automatic read(input logic psel, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_par_sel = psel; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    @(negedge clk);
    seen_pulse = obj_clr_valid;
  endtask

  task automatic t_reset;
    chk("R11 reset par_err", 32'(par_err), 0);
    chk("R4 reset rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_init;
    int n = 0;
    logic rdy_seen = 0;
    @(negedge clk); init_start = 1;
    @(negedge clk); init_start = 0;
    while (init_busy) begin
      n++;
      if (req_ready) rdy_seen = 1;
      @(negedge clk);
    end
    chk("R1 busy cycles", n, DEPTH);
    chk("R1 ready low while busy", 32'(rdy_seen), 0);
    par_en = 1;
    read(0, 0);              chk("R1 word 0 zero", rd, 0);
    read(0, AW'(DEPTH - 1)); chk("R1 top word zero", rd, 0);
    rda_mode = 1;
    read(1, AW'(DEPTH - 1)); chk("R1 top pbit zero", rd, 0);
    rda_mode = 0;
    chk("R1 no error after init", 32'(par_err), 0);
  endtask

  task automatic t_gen;
    par_en = 1;
    write(0, 3, 32'h0000_0007);
    write(0, 4, 32'h0000_0003);
    rda_mode = 1;
    read(1, 3); chk("R2 odd word pbit", rd, 1);
    read(1, 4); chk("R2 even word pbit", rd, 0);
    rda_mode = 0;
    read(0, 3); chk("R2 data back", rd, 32'h7);
    chk("R2 no error", 32'(par_err), 0);
  endtask

  task automatic t_disabled;
    par_en = 0;
    write(0, 4, 32'h0000_0001);
    dbg_mode = 1;
    read(1, 4); chk("R3 pbit unchanged", rd, 0);
    dbg_mode = 0;
    read(0, 4); chk("R3 no check when disabled", 32'(par_err), 0);
    par_en = 1; irq_en = 1;
    read(0, 4);
    chk("R4 data returned on error", rd, 32'h1);
    chk("R7 clear pulse", 32'(seen_pulse), 1);
    chk("R5 error flag", 32'(par_err), 1);
    chk("R6 error addr", 32'(err_addr), 4);
    chk("R7 pulse addr", 32'(obj_clr_addr), 4);
    chk("R8 irq on", 32'(err_irq), 1);
    @(negedge clk);
    chk("R7 single-cycle pulse", 32'(obj_clr_valid), 0);
    irq_en = 0; #1;
    chk("R8 irq masked", 32'(err_irq), 0);
    irq_en = 1;
    read(0, 3);
    chk("R5 sticky after clean read", 32'(par_err), 1);
  endtask

  task automatic t_clear;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk("R11 flag cleared", 32'(par_err), 0);
    chk("R11 addr cleared", 32'(err_addr), 0);
    chk("R11 irq cleared", 32'(err_irq), 0);
    irq_en = 0;
  endtask

  task automatic t_pbit_write;
    par_en = 1; rda_mode = 1;
    write(1, 3, 32'h0);
    read(1, 3); chk("R10 ignored while checking on", rd, 1);
    par_en = 0; rda_mode = 0;
    write(1, 3, 32'h0);
    rda_mode = 1;
    read(1, 3); chk("R10 ignored outside test mode", rd, 1);
    write(1, 3, 32'hFFFF_FFFE);
    read(1, 3); chk("R10 test write bit0", rd, 0);
    write(1, 5, 32'h1);
    rda_mode = 0;
    read(1, 3); chk("R9 pbit hidden outside modes", rd, 0);
    par_en = 1; rda_mode = 1;
    read(1, 3); chk("R9 pbit read not checked", 32'(seen_pulse), 0);
    rda_mode = 0;
    read(0, 3); chk("R6 first error addr", 32'(err_addr), 3);
    read(0, 5); chk("R6 overwrite addr", 32'(err_addr), 5);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_stall;
    logic [31:0] first;
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_par_sel = 0; req_addr = 3;
    @(negedge clk);
    req_valid = 0;
    first = rsp_rdata;
    chk("R4 response valid", 32'(rsp_valid), 1);
    chk("R4 ready low on stall", 32'(req_ready), 0);
    @(negedge clk); @(negedge clk);
    chk("R4 still valid", 32'(rsp_valid), 1);
    chk("R4 data held", rsp_rdata, first);
    chk("R4 data value", first, 32'h7);
    rsp_ready = 1;
    @(negedge clk);
    chk("R4 taken", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init();
    t_gen();
    t_disabled();
    t_clear();
    t_pbit_write();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule